// File: doc/BRIEF.md
# Readout Card Bus Decoder

This block sits between a DSP's memory-mapped peripheral bus and a two-channel readout card. It decides whether a bus cycle belongs to this card by comparing bus lines against a 4-bit card identity set by configuration straps. When a read matches, it returns one of the card's two converter results on the data bus. When a write matches, it updates the bias-DAC path. That path has a value latch and an active-low control latch. Each falling bit of the control latch sends a one-cycle load strobe to its DAC channel.

Reads and writes check different lines against the identity. A read compares address bits 3..1 and the X/Y space select, and address bit 0 picks the converter. A write compares data bits 15..13 and address bit 0, and data bit 12 must be clear. Address bit 1 of a write selects the latch it targets. Address bits 3..2 and the space select are not used on writes. Setting a DAC therefore takes two accepted writes: the value first, then a control word with the channel's bit low.

Top module: `rocard_decode`

## Requirements
- R1: After reset, `rd_oe` is 0, `rd_data` is 0, `dac_value` is 0 and no `dac_load` bit is set. All control-latch bits reset to 1, their idle level.
- R2: A read is accepted when all of these hold: `bus_rd` is 1, `bus_addr[15:4]` equals `WIN_BASE` (default 12'hFFB), and {`bus_addr[3]`, `bus_addr[2]`, `bus_addr[1]`, `bus_ysel`} equals the effective identity. On the cycle after the strobe is sampled, `rd_oe` is 1.
- R3: On an accepted read, `rd_data` the next cycle is the zero-extended `conv0_res` when `bus_addr[0]` is 0, and `conv1_res` when it is 1.
- R4: When no read is accepted in a cycle, `rd_oe` is 0 and `rd_data` is 0 on the next cycle. This covers a wrong window, a wrong identity and a missing strobe.
- R5: A write is accepted only when `bus_addr[15:4]` equals `WIN_BASE` and {`bus_wdata[15]`, `bus_wdata[14]`, `bus_wdata[13]`, `bus_addr[0]`} equals the effective identity. A write that is not accepted changes neither latch.
- R6: A write with `bus_wdata[12]` = 1 is ignored.
- R7: An accepted write with `bus_addr[1]` = 0 loads `bus_wdata[11:0]` into `dac_value`, visible the next cycle. One with `bus_addr[1]` = 1 loads `bus_wdata[7:0]` into the control latch.
- R8: `dac_load[k]` is 1 for exactly one cycle, the cycle after the write that takes control bit k from 1 to 0. Holding the bit at 0 or raising it gives no strobe.
- R9: With `STRAP_INV` = 0 the effective identity is `strap_id`. With `STRAP_INV` = 1 it is the bitwise complement of `strap_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_ysel | input | 1 | Memory space select, 1 = Y space |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 24 | Write data |
| strap_id | input | 4 | Card identity straps |
| conv0_res | input | 16 | First converter result |
| conv1_res | input | 16 | Second converter result |
| rd_data | output | 24 | Read data, zero when not enabled |
| rd_oe | output | 1 | Read data output enable |
| dac_value | output | 12 | Latched DAC value |
| dac_load | output | 8 | Per-channel DAC load strobes |

## Verification
Most random bus cycles land inside the address window but carry random low address bits, space select and data bits 15..12. Matches and near-misses therefore both occur, and the bench can tell a wrong choice of identity lines on each direction from a correct decode. Random control words alternate between lowering and raising bits. This separates strobing on the 1-to-0 edge from strobing on the level or on the rising edge. A second instance with inverted strap sense sees the same bus, so a missing or doubled inversion appears as one instance answering where the other should. Directed cases cover the worked identity-2 addresses, the data-bit-12 veto, and a held-low control bit.

// File: rtl/rocard_pkg.sv
package rocard_pkg;
  localparam int ID_W = 4;
  typedef logic [ID_W-1:0] card_id_t;

  typedef enum logic {
    LATCH_VALUE = 1'b0,
    LATCH_CTRL  = 1'b1
  } latch_sel_e;
endpackage

// File: rtl/rocard_id_match.sv
module rocard_id_match
  import rocard_pkg::*;
#(
  parameter bit STRAP_INV = 1'b0
) (
  input  card_id_t strap_id,
  input  card_id_t rd_key,
  input  card_id_t wr_key,
  output logic     rd_id_ok,
  output logic     wr_id_ok
);
  card_id_t eff_id;

  generate
    if (STRAP_INV) begin : g_inv
      assign eff_id = ~strap_id;
    end else begin : g_dir
      assign eff_id = strap_id;
    end
  endgenerate

  always_comb begin
    rd_id_ok = (rd_key == eff_id);
    wr_id_ok = (wr_key == eff_id);
  end
endmodule

// File: rtl/rocard_read_port.sv
module rocard_read_port #(
  parameter int ADC_W  = 16,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  logic              rd_odd,
  input  logic [ADC_W-1:0]  conv0_res,
  input  logic [ADC_W-1:0]  conv1_res,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  localparam int PAD_W = DATA_W - ADC_W;

  logic              oe_d, oe_q;
  logic [DATA_W-1:0] data_d, data_q;
  logic [ADC_W-1:0]  pick;

  always_comb begin
    pick   = rd_odd ? conv1_res : conv0_res;
    oe_d   = rd_hit;
    data_d = rd_hit ? {{PAD_W{1'b0}}, pick} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      oe_q   <= oe_d;
      data_q <= data_d;
    end
  end

  assign rd_oe   = oe_q;
  assign rd_data = data_q;
endmodule

// File: rtl/rocard_bias_latch.sv
module rocard_bias_latch #(
  parameter int DAC_W   = 12,
  parameter int NUM_DAC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               val_en,
  input  logic               ctl_en,
  input  logic [DAC_W-1:0]   val_in,
  input  logic [NUM_DAC-1:0] ctl_in,
  output logic [DAC_W-1:0]   dac_value,
  output logic [NUM_DAC-1:0] dac_load
);
  logic [DAC_W-1:0]   val_d, val_q;
  logic [NUM_DAC-1:0] ctl_d, ctl_q;
  logic [NUM_DAC-1:0] prev_d, prev_q;

  always_comb begin
    val_d  = val_en ? val_in : val_q;
    ctl_d  = ctl_en ? ctl_in : ctl_q;
    prev_d = ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      ctl_q  <= '1;
      prev_q <= '1;
    end else begin
      val_q  <= val_d;
      ctl_q  <= ctl_d;
      prev_q <= prev_d;
    end
  end

  generate
    for (genvar k = 0; k < NUM_DAC; k++) begin : g_strobe
      assign dac_load[k] = prev_q[k] & ~ctl_q[k];
    end
  endgenerate

  assign dac_value = val_q;
endmodule

// File: rtl/rocard_decode.sv
module rocard_decode
  import rocard_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 24,
  parameter int          ADC_W     = 16,
  parameter int          DAC_W     = 12,
  parameter int          NUM_DAC   = 8,
  parameter logic [11:0] WIN_BASE  = 12'hFFB,
  parameter bit          STRAP_INV = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_ysel,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [ID_W-1:0]    strap_id,
  input  logic [ADC_W-1:0]   conv0_res,
  input  logic [ADC_W-1:0]   conv1_res,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_oe,
  output logic [DAC_W-1:0]   dac_value,
  output logic [NUM_DAC-1:0] dac_load
);
  localparam int WIN_LSB = 4;
  localparam int VETO_B  = 12;

  card_id_t   rd_key, wr_key;
  logic       rd_id_ok, wr_id_ok;
  logic       in_window, rd_hit, wr_ok;
  latch_sel_e wr_target;
  logic       val_en, ctl_en;
  logic [DATA_W-1:16] wdata_unused;

  always_comb begin
    in_window = (bus_addr[ADDR_W-1:WIN_LSB] == WIN_BASE);
    rd_key    = {bus_addr[3], bus_addr[2], bus_addr[1], bus_ysel};
    wr_key    = {bus_wdata[15], bus_wdata[14], bus_wdata[13], bus_addr[0]};
    wr_target = latch_sel_e'(bus_addr[1]);
  end

  rocard_id_match #(.STRAP_INV(STRAP_INV)) id_i (
    .strap_id (strap_id),
    .rd_key   (rd_key),
    .wr_key   (wr_key),
    .rd_id_ok (rd_id_ok),
    .wr_id_ok (wr_id_ok)
  );

  always_comb begin
    rd_hit = bus_rd & in_window & rd_id_ok;
    wr_ok  = bus_wr & in_window & wr_id_ok & ~bus_wdata[VETO_B];
    val_en = wr_ok & (wr_target == LATCH_VALUE);
    ctl_en = wr_ok & (wr_target == LATCH_CTRL);
  end

  assign wdata_unused = bus_wdata[DATA_W-1:16];

  rocard_read_port #(.ADC_W(ADC_W), .DATA_W(DATA_W)) rp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_hit    (rd_hit),
    .rd_odd    (bus_addr[0]),
    .conv0_res (conv0_res),
    .conv1_res (conv1_res),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe)
  );

  rocard_bias_latch #(.DAC_W(DAC_W), .NUM_DAC(NUM_DAC)) bl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .val_en    (val_en),
    .ctl_en    (ctl_en),
    .val_in    (bus_wdata[DAC_W-1:0]),
    .ctl_in    (bus_wdata[NUM_DAC-1:0]),
    .dac_value (dac_value),
    .dac_load  (dac_load)
  );
endmodule

// File: rtl/rocard_decode_chk.sv
module rocard_decode_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 24,
  parameter int ADC_W   = 16,
  parameter int DAC_W   = 12,
  parameter int NUM_DAC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [ADC_W-1:0]   conv0_res,
  input logic [ADC_W-1:0]   conv1_res,
  input logic [DATA_W-1:0]  rd_data,
  input logic               rd_oe,
  input logic [DAC_W-1:0]   dac_value,
  input logic [NUM_DAC-1:0] dac_load
);
  localparam int PAD_W = DATA_W - ADC_W;

  // R2: output enable only follows a sampled read strobe
  p_oe_needs_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> $past(bus_rd));

  // R4: bus data is quiet whenever the output is not enabled
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));

  // R3: even address returns the first converter
  p_even_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && !$past(bus_addr[0])) |-> (rd_data == {{PAD_W{1'b0}}, $past(conv0_res)}));

  // R3: odd address returns the second converter
  p_odd_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && $past(bus_addr[0])) |-> (rd_data == {{PAD_W{1'b0}}, $past(conv1_res)}));

  // R6: value latch moves only on a write with data bit 12 clear
  p_veto_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_value != $past(dac_value)) |-> ($past(bus_wr) && !$past(bus_wdata[12])));

  // R8: each strobe lasts a single cycle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_load & $past(dac_load)) == '0);

  // R8: a strobe follows a write on the previous edge
  p_load_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|dac_load) |-> $past(bus_wr));
endmodule

bind rocard_decode rocard_decode_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADC_W(ADC_W), .DAC_W(DAC_W), .NUM_DAC(NUM_DAC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .conv0_res(conv0_res), .conv1_res(conv1_res),
  .rd_data(rd_data), .rd_oe(rd_oe), .dac_value(dac_value), .dac_load(dac_load)
);

// File: tb/rocard_decode_tb.sv
module rocard_decode_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_ysel = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [23:0] bus_wdata = '0;
  logic [3:0]  strap_id = 4'd2;
  logic [15:0] conv0_res = 16'h1234;
  logic [15:0] conv1_res = 16'hBEEF;

  logic [23:0] rd_data_a, rd_data_b;
  logic        rd_oe_a, rd_oe_b;
  logic [11:0] dac_value_a, dac_value_b;
  logic [7:0]  dac_load_a, dac_load_b;

  int n_cmp = 0;
  int n_bad = 0;

  logic [11:0] m_val [2];
  logic [7:0]  m_ctl [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  rocard_decode #(.STRAP_INV(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ysel(bus_ysel),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .strap_id(strap_id),
    .conv0_res(conv0_res), .conv1_res(conv1_res), .rd_data(rd_data_a),
    .rd_oe(rd_oe_a), .dac_value(dac_value_a), .dac_load(dac_load_a)
  );

  rocard_decode #(.STRAP_INV(1'b1)) dut_inv_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ysel(bus_ysel),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .strap_id(strap_id),
    .conv0_res(conv0_res), .conv1_res(conv1_res), .rd_data(rd_data_b),
    .rd_oe(rd_oe_b), .dac_value(dac_value_b), .dac_load(dac_load_b)
  );

  function automatic logic [3:0] eff_id(input logic [3:0] s, input logic inv);
    return inv ? ~s : s; // R9
  endfunction

  function automatic logic rd_match(input logic [15:0] a, input logic ys,
                                    input logic [3:0] s, input logic inv);
    return (a[15:4] == 12'hFFB) && ({a[3], a[2], a[1], ys} == eff_id(s, inv));
  endfunction

  function automatic logic wr_match(input logic [15:0] a, input logic [23:0] wd,
                                    input logic [3:0] s, input logic inv);
    return (a[15:4] == 12'hFFB) && ({wd[15], wd[14], wd[13], a[0]} == eff_id(s, inv))
           && !wd[12];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_op(input logic rd, input logic wr, input logic [15:0] a,
                       input logic ys, input logic [23:0] wd, input string tag);
    logic        e_oe [2];
    logic [23:0] e_dat [2];
    logic [7:0]  e_ld [2];
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_ysel = ys; bus_wdata = wd;
    for (int k = 0; k < 2; k++) begin
      e_oe[k]  = rd && rd_match(a, ys, strap_id, k[0]);
      e_dat[k] = e_oe[k] ? {8'h00, (a[0] ? conv1_res : conv0_res)} : 24'h0;
      e_ld[k]  = 8'h00;
      if (wr && wr_match(a, wd, strap_id, k[0])) begin
        if (a[1]) begin
          e_ld[k]  = m_ctl[k] & ~wd[7:0];
          m_ctl[k] = wd[7:0];
        end else begin
          m_val[k] = wd[11:0];
        end
      end
    end
    @(negedge clk);
    check({tag, " oe direct"},  {31'd0, rd_oe_a}, {31'd0, e_oe[0]});
    check({tag, " data direct"}, {8'd0, rd_data_a}, {8'd0, e_dat[0]});
    check({tag, " value direct"}, {20'd0, dac_value_a}, {20'd0, m_val[0]});
    check({tag, " load direct"}, {24'd0, dac_load_a}, {24'd0, e_ld[0]});
    check({tag, " oe inv R9"},  {31'd0, rd_oe_b}, {31'd0, e_oe[1]});
    check({tag, " data inv R9"}, {8'd0, rd_data_b}, {8'd0, e_dat[1]});
    check({tag, " value inv R9"}, {20'd0, dac_value_b}, {20'd0, m_val[1]});
    check({tag, " load inv R9"}, {24'd0, dac_load_b}, {24'd0, e_ld[1]});
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    for (int k = 0; k < 2; k++) begin
      m_val[k] = '0; m_ctl[k] = '1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 oe", {31'd0, rd_oe_a}, 32'd0);
    check("R1 data", {8'd0, rd_data_a}, 32'd0);
    check("R1 value", {20'd0, dac_value_a}, 32'd0);
    check("R1 load", {24'd0, dac_load_a}, 32'd0);

    // identity 2: X:$FFB2 first converter, X:$FFB3 second
    do_op(1, 0, 16'hFFB2, 0, 24'h0, "R2 R3 even");
    do_op(1, 0, 16'hFFB3, 0, 24'h0, "R2 R3 odd");
    do_op(1, 0, 16'hFFB2, 1, 24'h0, "R4 wrong space");
    do_op(1, 0, 16'hFFC2, 0, 24'h0, "R4 wrong window");
    do_op(0, 0, 16'hFFB2, 0, 24'h0, "R4 no strobe");
    do_op(1, 0, 16'hFFBC, 1, 24'h0, "R9 inverted id Y:FFBC");
    // value write to $FFB0 with $xx2xxx
    do_op(0, 1, 16'hFFB0, 0, 24'h002ABC, "R7 value write");
    do_op(0, 1, 16'hFFB0, 0, 24'h003555, "R6 bit12 veto");
    do_op(0, 1, 16'hFFB0, 0, 24'h004777, "R5 wrong data id");
    do_op(0, 1, 16'hFFB1, 0, 24'h002777, "R5 wrong A00");
    // control: lower bit 3, hold it, raise it
    do_op(0, 1, 16'hFFB2, 0, 24'h0020F7, "R8 lower bit3");
    do_op(0, 1, 16'hFFB2, 0, 24'h0020F7, "R8 hold low");
    do_op(0, 1, 16'hFFB2, 0, 24'h0020FF, "R8 raise");
    do_op(0, 1, 16'hFFB2, 0, 24'h0030FE, "R6 ctrl veto");
    do_op(0, 1, 16'hFFB2, 0, 24'h0020FE, "R7 ctrl write");

    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      logic [23:0] wd;
      logic        ys;
      int          op;
      if ($urandom_range(0, 19) == 0) strap_id = 4'($urandom);
      conv0_res = 16'($urandom);
      conv1_res = 16'($urandom);
      a  = {($urandom_range(0, 7) == 0) ? 12'($urandom) : 12'hFFB, 4'($urandom)};
      ys = 1'($urandom);
      wd = 24'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        wd[15:13] = eff_id(strap_id, 1'b0)[3:1];
        a[0]      = eff_id(strap_id, 1'b0)[0];
        wd[12]    = ($urandom_range(0, 3) == 0);
      end
      op = $urandom_range(0, 2);
      do_op(op == 0, op == 1, a, ys, wd, "R2 R3 R5 R7 R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule